// File: doc/BRIEF.md
# ADC Histogram Linearity Analyzer

This block measures the static linearity of an analog-to-digital converter from its output codes. While a slow linear ramp sweeps the converter across its full input span, every valid output code lands in a per-code hit counter. The record ends after a programmed number of accepted samples or on an early stop request. The block then makes two passes over the bins, one code per clock. The first pass builds the running cumulative count. The second turns each interior bin into a differential nonlinearity figure with 8 fractional bits. Over both passes it also gathers the worst-case magnitude and a count of empty codes.

The two end codes also collect input that lies beyond the converter's range. They are therefore left out of the ideal-width estimate, the DNL figures and the worst-case value. Per-code results are read back through an address/data port with one cycle of latency. A done level and a few summary outputs give the totals.

The controller is a five-state machine. IDLE is left only on `start`. COLLECT runs until the record is complete (`stop` or accepted count equal to `rec_len`), then moves to SUM_PASS. SUM_PASS moves to DNL_PASS after the last code. DNL_PASS moves to DONE after the last code. DONE holds. A `start` in any state clears everything and enters COLLECT.

Top module: `adh_hist_dnl`

## Requirements
- R1: After reset, `done`, `busy` and `overflow` are 0, and `worst_dnl` and `missing_total` are 0.
- R2: A one-cycle `start` in any state clears every bin, cumulative entry, DNL entry, the overflow flag and both summaries. In the following cycle `done` is 0 and `busy` is 1.
- R3: While collecting, each cycle with `smp_valid` high and `stop` low adds one to the bin of `smp_code`. Cycles with `smp_valid` low change no bin.
- R4: Collection ends once `rec_len` samples have been accepted, or in a cycle where `stop` is high. Samples offered after that, or together with `stop`, are not counted. After the two passes `done` rises and stays high until the next `start`, and `busy` is 0 while `done` is high.
- R5: A bin holds at 2^CNT_W−1 instead of wrapping. `overflow` rises when a sample hits a bin already at that value, and stays set until `start`.
- R6: The cumulative output for code j equals the sum of the bins for codes 0 through j.
- R7: For an interior code k (neither 0 nor 2^CODE_W−1), the DNL output is a two's-complement value with 8 fractional bits. It equals floor(H[k]·(2^CODE_W−2)·256 / S) − 256, where S is the sum of the interior bins. When S is 0 the quotient is taken as 0, so the result is −256.
- R8: Codes 0 and 2^CODE_W−1 report a DNL of 0. Their counts contribute neither to S nor to `worst_dnl`.
- R9: `worst_dnl` equals the largest absolute DNL over the interior codes. It is unchanged while `done` stays high.
- R10: The missing flag for a code (any code, ends included) is 1 exactly when its bin is 0. `missing_total` is the number of such codes.
- R11: The read outputs show the entry for the `rd_addr` that was sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear and begin a new record |
| stop | input | 1 | End collection early |
| rec_len | input | LEN_W | Number of samples to accept |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| rd_addr | input | CODE_W | Code selected for readout |
| rd_count | output | CNT_W | Bin count of the selected code |
| rd_cum | output | CNT_W+CODE_W | Cumulative count up to the selected code |
| rd_dnl | output | CODE_W+10 | Signed DNL, 8 fractional bits |
| rd_missing | output | 1 | Selected code was never hit |
| busy | output | 1 | Collecting or processing |
| done | output | 1 | Results valid |
| worst_dnl | output | CODE_W+10 | Largest interior DNL magnitude |
| missing_total | output | CODE_W+1 | Number of codes never hit |
| overflow | output | 1 | A hit was lost at a full bin |

## Verification
The bench builds the block with 4-bit codes, 8-bit bins and a 12-bit record length. Sixteen bins make a full readout sweep short. The 8-bit counters let a single code reach saturation within 256 samples, so both the last lossless hit and the first lost hit can be exercised. With only fourteen interior codes, a record that lands entirely on the end codes drives the interior sum to zero. A record on one interior code then yields the largest possible DNL quotient.

// File: rtl/adh_pkg.sv
package adh_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_COLLECT = 3'd1,
        S_SUM     = 3'd2,
        S_DNL     = 3'd3,
        S_DONE    = 3'd4
    } adh_state_e;
endpackage

// File: rtl/adh_bins.sv
module adh_bins #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hit,
    input  logic [CODE_W-1:0] hit_code,
    input  logic [CODE_W-1:0] a_idx,
    output logic [CNT_W-1:0]  a_cnt,
    input  logic [CODE_W-1:0] b_idx,
    output logic [CNT_W-1:0]  b_cnt,
    output logic              ovf
);
    localparam int NCODE = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] bin_cnt [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_bin
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (clr)
                cnt_q <= '0;
            else if (hit && hit_code == CODE_W'(g) && cnt_q != CMAX)
                cnt_q <= cnt_q + 1'b1;
        end
        assign bin_cnt[g] = cnt_q;
    end

    assign a_cnt = bin_cnt[a_idx];
    assign b_cnt = bin_cnt[b_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (clr)
            ovf <= 1'b0;
        else if (hit && bin_cnt[hit_code] == CMAX)
            ovf <= 1'b1;
    end
endmodule

// File: rtl/adh_dnl_calc.sv
module adh_dnl_calc #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic [CNT_W-1:0]               cnt,
    input  logic [CNT_W+CODE_W-1:0]        int_sum,
    input  logic                           is_end,
    output logic signed [CODE_W+9:0]       dnl,
    output logic [CODE_W+9:0]              mag
);
    localparam int NUM_W = CNT_W + CODE_W + 8;
    localparam int DNL_W = CODE_W + 10;
    localparam int NINT  = (1 << CODE_W) - 2;

    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] den;
    logic [NUM_W-1:0] quo;

    always_comb begin
        num = (NUM_W'(cnt) * NUM_W'(NINT)) << 8;
        den = NUM_W'(int_sum);
        quo = (den == '0) ? '0 : num / den;
        if (is_end)
            dnl = '0;
        else
            dnl = $signed(DNL_W'(quo)) - $signed(DNL_W'(256));
        mag = dnl[DNL_W-1] ? DNL_W'(-dnl) : DNL_W'(dnl);
    end
endmodule

// File: rtl/adh_results.sv
module adh_results #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        cum_we,
    input  logic                        dnl_we,
    input  logic [CODE_W-1:0]           waddr,
    input  logic [CNT_W+CODE_W-1:0]     wcum,
    input  logic signed [CODE_W+9:0]    wdnl,
    input  logic [CODE_W-1:0]           raddr,
    input  logic [CNT_W-1:0]            rcnt_in,
    output logic [CNT_W-1:0]            rcnt,
    output logic [CNT_W+CODE_W-1:0]     rcum,
    output logic signed [CODE_W+9:0]    rdnl
);
    localparam int NCODE = 1 << CODE_W;
    localparam int SUM_W = CNT_W + CODE_W;
    localparam int DNL_W = CODE_W + 10;

    logic [SUM_W-1:0]        cum_mem [NCODE];
    logic signed [DNL_W-1:0] dnl_mem [NCODE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NCODE; i++) begin
                cum_mem[i] <= '0;
                dnl_mem[i] <= '0;
            end
        end else begin
            if (cum_we) cum_mem[waddr] <= wcum;
            if (dnl_we) dnl_mem[waddr] <= wdnl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt <= '0;
            rcum <= '0;
            rdnl <= '0;
        end else begin
            rcnt <= rcnt_in;
            rcum <= cum_mem[raddr];
            rdnl <= dnl_mem[raddr];
        end
    end
endmodule

// File: rtl/adh_hist_dnl.sv
module adh_hist_dnl
    import adh_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      stop,
    input  logic [LEN_W-1:0]          rec_len,
    input  logic                      smp_valid,
    input  logic [CODE_W-1:0]         smp_code,
    input  logic [CODE_W-1:0]         rd_addr,
    output logic [CNT_W-1:0]          rd_count,
    output logic [CNT_W+CODE_W-1:0]   rd_cum,
    output logic signed [CODE_W+9:0]  rd_dnl,
    output logic                      rd_missing,
    output logic                      busy,
    output logic                      done,
    output logic [CODE_W+9:0]         worst_dnl,
    output logic [CODE_W:0]           missing_total,
    output logic                      overflow
);
    localparam int NCODE = 1 << CODE_W;
    localparam int SUM_W = CNT_W + CODE_W;
    localparam int DNL_W = CODE_W + 10;
    localparam logic [CODE_W-1:0] LAST = CODE_W'(NCODE - 1);

    adh_state_e state_q, state_d;

    logic [LEN_W-1:0]        taken_q;
    logic [CODE_W-1:0]       idx_q;
    logic [SUM_W-1:0]        cum_q, sint_q;
    logic [DNL_W-1:0]        worst_q;
    logic [CODE_W:0]         miss_q;

    logic                    accept, rec_end, idx_last, is_end;
    logic                    cum_we, dnl_we;
    logic [CNT_W-1:0]        cnt_idx, cnt_rd;
    logic [SUM_W-1:0]        cum_next;
    logic signed [DNL_W-1:0] dnl_val;
    logic [DNL_W-1:0]        dnl_mag;

    adh_bins #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .hit(accept), .hit_code(smp_code),
        .a_idx(idx_q), .a_cnt(cnt_idx),
        .b_idx(rd_addr), .b_cnt(cnt_rd),
        .ovf(overflow)
    );

    adh_dnl_calc #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_calc (
        .cnt(cnt_idx), .int_sum(sint_q), .is_end(is_end),
        .dnl(dnl_val), .mag(dnl_mag)
    );

    adh_results #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .cum_we(cum_we), .dnl_we(dnl_we), .waddr(idx_q),
        .wcum(cum_next), .wdnl(dnl_val),
        .raddr(rd_addr), .rcnt_in(cnt_rd),
        .rcnt(rd_count), .rcum(rd_cum), .rdnl(rd_dnl)
    );

    assign rd_missing = (rd_count == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        rec_end  = stop || (taken_q == rec_len);
        accept   = (state_q == S_COLLECT) && smp_valid && !rec_end && !start;
        idx_last = (idx_q == LAST);
        is_end   = (idx_q == '0) || idx_last;
        cum_next = cum_q + SUM_W'(cnt_idx);
        cum_we   = (state_q == S_SUM) && !start;
        dnl_we   = (state_q == S_DNL) && !start;
        busy     = (state_q == S_COLLECT) || (state_q == S_SUM) || (state_q == S_DNL);
        done     = (state_q == S_DONE);
        state_d  = state_q;
        unique case (state_q)
            S_IDLE:    state_d = S_IDLE;
            S_COLLECT: if (rec_end)  state_d = S_SUM;
            S_SUM:     if (idx_last) state_d = S_DNL;
            S_DNL:     if (idx_last) state_d = S_DONE;
            S_DONE:    state_d = S_DONE;
            default:   state_d = S_IDLE;
        endcase
        if (start) state_d = S_COLLECT;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || start) begin
            taken_q <= '0;
            idx_q   <= '0;
            cum_q   <= '0;
            sint_q  <= '0;
            worst_q <= '0;
            miss_q  <= '0;
        end else begin
            unique case (state_q)
                S_COLLECT: if (accept) taken_q <= taken_q + 1'b1;
                S_SUM: begin
                    cum_q <= cum_next;
                    if (!is_end) sint_q <= sint_q + SUM_W'(cnt_idx);
                    idx_q <= idx_q + 1'b1;
                end
                S_DNL: begin
                    if (!is_end && dnl_mag > worst_q) worst_q <= dnl_mag;
                    if (cnt_idx == '0) miss_q <= miss_q + 1'b1;
                    idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign worst_dnl     = worst_q;
    assign missing_total = miss_q;
endmodule

// File: rtl/adh_checker.sv
module adh_checker #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              overflow,
    input logic [CODE_W+9:0] worst_dnl,
    input logic [CODE_W:0]   missing_total
);
    localparam int NCODE = 1 << CODE_W;

    AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && busy)) else $error("start did not restart"); // R2

    AST_START_CLEARS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!overflow && worst_dnl == '0 && missing_total == '0)) else $error("summary not cleared"); // R2

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done) else $error("done dropped"); // R4

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)) else $error("busy with done"); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow) else $error("overflow lost"); // R5

    AST_WORST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(worst_dnl)) else $error("worst moved"); // R9

    AST_MISS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(missing_total) <= NCODE) else $error("missing count range"); // R10
endmodule

bind adh_hist_dnl adh_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_adh_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .overflow(overflow), .worst_dnl(worst_dnl), .missing_total(missing_total)
);

// File: tb/adh_hist_dnl_bench.sv
module adh_hist_dnl_bench;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 8;
    localparam int LEN_W  = 12;
    localparam int NCODE  = 1 << CODE_W;
    localparam int NINT   = NCODE - 2;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, smp_valid = 1'b0;
    logic [LEN_W-1:0] rec_len = '0;
    logic [CODE_W-1:0] smp_code = '0, rd_addr = '0;
    logic [CNT_W-1:0] rd_count;
    logic [CNT_W+CODE_W-1:0] rd_cum;
    logic signed [CODE_W+9:0] rd_dnl;
    logic rd_missing, busy, done, overflow;
    logic [CODE_W+9:0] worst_dnl;
    logic [CODE_W:0] missing_total;

    int total = 0, bad = 0;
    int mh [NCODE];
    bit movf;

    always #2 clk = ~clk;

    adh_hist_dnl #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_adh_hist_dnl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .rec_len(rec_len),
        .smp_valid(smp_valid), .smp_code(smp_code), .rd_addr(rd_addr),
        .rd_count(rd_count), .rd_cum(rd_cum), .rd_dnl(rd_dnl), .rd_missing(rd_missing),
        .busy(busy), .done(done), .worst_dnl(worst_dnl),
        .missing_total(missing_total), .overflow(overflow)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int int_sum();
        int s = 0;
        for (int k = 1; k < NCODE - 1; k++) s += mh[k];
        return s;
    endfunction

    function automatic int exp_dnl(input int k);
        int s;
        longint q;
        if (k == 0 || k == NCODE - 1) return 0;
        s = int_sum();
        q = (s == 0) ? 0 : (longint'(mh[k]) * NINT * 256) / s;
        return int'(q) - 256;
    endfunction

    function automatic int exp_worst();
        int w = 0, d;
        for (int k = 1; k < NCODE - 1; k++) begin
            d = exp_dnl(k);
            if (d < 0) d = -d;
            if (d > w) w = d;
        end
        return w;
    endfunction

    function automatic int exp_miss();
        int m = 0;
        for (int k = 0; k < NCODE; k++) if (mh[k] == 0) m++;
        return m;
    endfunction

    task automatic do_start(input int len);
        @(negedge clk);
        rec_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < NCODE; k++) mh[k] = 0;
        movf = 1'b0;
        chk("R2 done low after start", done, 0);
        chk("R2 busy after start", busy, 1);
    endtask

    // drive one cycle of stimulus; counted marks whether the model accepts it
    task automatic drive(input bit v, input int code, input bit counted);
        smp_valid = v;
        smp_code = CODE_W'(code);
        @(negedge clk);
        smp_valid = 1'b0;
        if (v && counted) begin
            if (mh[code] < CMAX) mh[code]++;
            else movf = 1'b1;
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R4 done reached", done, 1);
        chk("R4 busy low when done", busy, 0);
    endtask

    task automatic check_all(input string tag);
        int cum = 0;
        for (int k = 0; k < NCODE; k++) begin
            rd_addr = CODE_W'(k);
            @(negedge clk);
            cum += mh[k];
            chk({tag, " R3 count"}, rd_count, mh[k]);
            chk({tag, " R6 cumulative"}, rd_cum, cum);
            if (k == 0 || k == NCODE - 1)
                chk({tag, " R8 end dnl"}, rd_dnl, 0);
            else
                chk({tag, " R7 dnl"}, rd_dnl, exp_dnl(k));
            chk({tag, " R10 missing flag"}, rd_missing, mh[k] == 0);
        end
        chk({tag, " R9 worst"}, worst_dnl, exp_worst());
        chk({tag, " R10 missing total"}, missing_total, exp_miss());
        chk({tag, " R5 overflow"}, overflow, movf);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int c;
        void'($urandom(32'd4242));
        for (int k = 0; k < NCODE; k++) mh[k] = 0;
        movf = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 worst", worst_dnl, 0);
        chk("R1 missing", missing_total, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // random ramp-like record, code 5 never produced, gaps ignored (R3)
        do_start(300);
        for (int n = 0; n < 300; ) begin
            c = int'($urandom % NCODE);
            if (c == 5) c = 6;
            if ($urandom % 4 == 0) drive(1'b0, c, 1'b0);
            else begin
                drive(1'b1, c, 1'b1);
                n++;
            end
        end
        // R4: a sample beyond the record length is not counted
        drive(1'b1, 9, 1'b0);
        wait_done();
        check_all("rand");
        // R11: before the edge the port still shows the old address
        rd_addr = 4'd5;
        @(negedge clk);
        rd_addr = 4'd9;
        #1;
        chk("R11 old value before edge", rd_count, mh[5]);
        @(negedge clk);
        chk("R11 new value after edge", rd_count, mh[9]);
        // R4 done holds
        repeat (5) @(negedge clk);
        chk("R4 done held", done, 1);

        // early stop: sample beside stop and after are ignored (R4)
        do_start(1000);
        for (int n = 0; n < 40; n++) drive(1'b1, 1 + int'($urandom % NINT), 1'b1);
        stop = 1'b1;
        drive(1'b1, 7, 1'b0);
        stop = 1'b0;
        for (int n = 0; n < 5; n++) drive(1'b1, 7, 1'b0);
        wait_done();
        check_all("stop");

        // saturation boundary: last lossless hit (R5)
        do_start(CMAX);
        for (int n = 0; n < CMAX; n++) drive(1'b1, 3, 1'b1);
        wait_done();
        check_all("sat255");
        chk("R7 single code peak", worst_dnl, NINT * 256 - 256);

        // first lost hit raises overflow (R5), then start clears it (R2)
        do_start(CMAX + 1);
        for (int n = 0; n < CMAX + 1; n++) drive(1'b1, 3, 1'b1);
        wait_done();
        check_all("sat256");
        do_start(4);
        chk("R2 overflow cleared", overflow, 0);

        // only end codes hit: interior sum zero (R7, R8)
        for (int n = 0; n < 4; n++) drive(1'b1, (n % 2) ? NCODE - 1 : 0, 1'b1);
        wait_done();
        check_all("ends");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule